// File: doc/BRIEF.md
# ACPI Sleep-State Rail Sequencer

This block turns the system's active-low sleep requests, the main supply's good flag, an enable and a standby-supply-present flag into one of four power states. From that state it drives the gate enables of an external switch network: a shared main pass switch that feeds the 5 V and 3.3 V dual rails from the main supply, two standby pass switches that feed the same rails from standby power, and an enable for a linear regulator. All inputs arrive as clean, already-synchronized levels. Analog sensing is outside the block. A rail that sags below about half its nominal voltage reaches it only as a one-bit undervoltage flag.

The states are `PS_OFF` (disabled), `PS_S0` (running), `PS_S3` (suspend to RAM) and `PS_S5` (soft off). The named transitions are:
- **arm**: `PS_OFF` to any state, on the first valid request.
- **wake**: `PS_S3` or `PS_S5` to `PS_S0`.
- **suspend**: `PS_S0` or `PS_S5` to `PS_S3`.
- **shutdown**: `PS_S0` to `PS_S5`.
- **disarm**: any state to `PS_OFF`, while the enable is low or standby power is missing.

The move from `PS_S3` straight to `PS_S5` is refused.

A fault guard watches the undervoltage flags of the two dual rails, but only while a rail is switched on. When a flag stays high for a programmable number of cycles, it latches an overcurrent fault that shuts every gate. Only toggling the enable or losing standby power clears that latch.

Top module: `acpi_rail_seq`

## Requirements
- R1: Request decode, with `sleep3_n_i`/`sleep5_n_i` written as a pair: 11 with `main_good_i`=1 requests S0; 01 requests S3; 00 requests S5. The state takes the request at the next clock edge.
- R2: A request for S5 while in S3 is ignored and the state stays S3. S5 is reached from S3 only after passing through S0.
- R3: `gate_main5_o` and `gate_main3_o` are both high in S0 and low in S3, S5 and OFF.
- R4: `gate_sby5_o` is high in S3, and in S5 only while `keep_usb_i`=1. It is low in S0, in OFF, and in S5 with `keep_usb_i`=0.
- R5: `gate_sby3_o` is high in S3, and in S5 only while `keep_pci_i`=1. It is low in S0, in OFF, and in S5 with `keep_pci_i`=0.
- R6: `keep_usb_i` and `keep_pci_i` have no effect on any output in S0 or S3.
- R7: `gate_lin_o` is high from the clock edge after `enable_i` and `sby_good_i` are both high, as long as no fault is latched. It drops in the same edge that latches a fault.
- R8: While `enable_i`=0 or `sby_good_i`=0, every gate output is low at once and the state returns to OFF at the next edge. After release, the first valid request sets the state. The pair 10 is not a valid request and holds the current state.
- R9: `main_good_i` falling while both sleep inputs stay high keeps the state at S0.
- R10: An undervoltage flag on an enabled rail (bit 0 the 5 V dual rail, bit 1 the 3.3 V dual rail) that is high for `TIMEOUT_CYC` consecutive clock edges latches a fault at the last of those edges. A shorter run does not latch, and the count restarts from zero whenever the flag drops.
- R11: A rail counts as enabled when its main or its standby gate is high. The undervoltage flag of a disabled rail is ignored, however long it stays high.
- R12: A latched fault forces all five gate outputs low and stays latched until `enable_i` or `sby_good_i` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Block enable; low disarms and clears a fault |
| sby_good_i | input | 1 | Standby supply above lockout |
| sleep3_n_i | input | 1 | Active-low suspend-to-RAM request |
| sleep5_n_i | input | 1 | Active-low soft-off request |
| main_good_i | input | 1 | Main supply good |
| keep_usb_i | input | 1 | Keep 5 V dual rail on in S5 |
| keep_pci_i | input | 1 | Keep 3.3 V dual rail on in S5 |
| uv_flag_i | input | 2 | Rail undervoltage flags: bit 0 5 V dual, bit 1 3.3 V dual |
| gate_main5_o | output | 1 | Main switch gate, 5 V dual |
| gate_main3_o | output | 1 | Main switch gate, 3.3 V dual |
| gate_sby5_o | output | 1 | Standby switch gate, 5 V dual |
| gate_sby3_o | output | 1 | Standby switch gate, 3.3 V dual |
| gate_lin_o | output | 1 | Linear regulator enable |

## Verification
The gate decode is swept over every keep-alive combination in S0, S3 and S5. This separates the state-only outputs from those that follow the keep-alive pins, and it shows that the pins are ignored outside S5. Request sequences S3 to S5 and S3 to S0 to S5 separate the refused move from the legal route. The invalid pair and a falling supply-good test the hold behaviour.

Undervoltage runs of exactly one cycle short of the timeout, runs broken by a single low cycle, and full-length runs separate glitch rejection and the counter restart from true latching. A long flag on a rail switched off in S5 shows the masking. Releasing the fault through the enable and, separately, through standby loss shows both clear paths.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF = 2'd0,
        PS_S0  = 2'd1,
        PS_S3  = 2'd2,
        PS_S5  = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_S0   = 2'd1,
        REQ_S3   = 2'd2,
        REQ_S5   = 2'd3
    } pwr_req_e;

    localparam int unsigned RAIL_CNT = 2;
    localparam int unsigned RAIL_5V  = 0;
    localparam int unsigned RAIL_3V  = 1;

endpackage

// File: rtl/rs_state_fsm.sv
module rs_state_fsm
    import rail_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       disarm_i,
    input  logic       sleep3_n_i,
    input  logic       sleep5_n_i,
    input  logic       main_good_i,
    output pwr_state_e state_o
);

    pwr_state_e state_q;
    pwr_state_e state_d;
    pwr_req_e   req;

    // Request decode from the sleep pair and supply-good
    always_comb begin
        unique case ({sleep3_n_i, sleep5_n_i})
            2'b11:   req = main_good_i ? REQ_S0 : REQ_NONE;
            2'b01:   req = REQ_S3;
            2'b00:   req = REQ_S5;
            default: req = REQ_NONE;
        endcase
    end

    // Transition selection
    always_comb begin
        state_d = state_q;
        if (disarm_i) begin
            state_d = PS_OFF;
        end else begin
            unique case (req)
                REQ_NONE: state_d = state_q;
                REQ_S0:   state_d = PS_S0;
                REQ_S3:   state_d = PS_S3;
                REQ_S5:   state_d = (state_q == PS_S3) ? PS_S3 : PS_S5;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R2: suspend may never lead straight to soft-off
    assert_no_s3_to_s5_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_S3) |=> (state_q != PS_S5));

    // R8: disarm always lands in OFF
    assert_disarm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_i |=> (state_q == PS_OFF));

endmodule

// File: rtl/rs_gate_decode.sv
module rs_gate_decode
    import rail_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_e state_i,
    input  logic       live_i,
    input  logic       fault_i,
    input  logic       keep_usb_i,
    input  logic       keep_pci_i,
    output logic       main_o,
    output logic       sby5_o,
    output logic       sby3_o
);

    logic main_raw, sby5_raw, sby3_raw;

    always_comb begin
        main_raw = 1'b0;
        sby5_raw = 1'b0;
        sby3_raw = 1'b0;
        unique case (state_i)
            PS_OFF: ;
            PS_S0:  main_raw = 1'b1;
            PS_S3: begin
                sby5_raw = 1'b1;
                sby3_raw = 1'b1;
            end
            PS_S5: begin
                sby5_raw = keep_usb_i;
                sby3_raw = keep_pci_i;
            end
        endcase
    end

    assign main_o = main_raw & live_i & ~fault_i;
    assign sby5_o = sby5_raw & live_i & ~fault_i;
    assign sby3_o = sby3_raw & live_i & ~fault_i;

    // R3/R4/R5: a rail is never fed from both supplies at once
    assert_no_cross_feed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        main_o |-> (!sby5_o && !sby3_o));

    // R12: fault blanks the switch gates
    assert_fault_blank_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |-> (!main_o && !sby5_o && !sby3_o));

endmodule

// File: rtl/rs_fault_guard.sv
module rs_fault_guard
    import rail_seq_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 16,
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [RAIL_CNT-1:0] rail_en_i,
    input  logic [RAIL_CNT-1:0] uv_i,
    output logic                fault_o,
    output logic                lin_o
);

    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [RAIL_CNT-1:0] expire;
    logic                fault_q;
    logic                lin_q;

    for (genvar r = 0; r < RAIL_CNT; r++) begin : g_rail
        logic [CW-1:0] cnt_q;
        logic          watch;

        assign watch     = uv_i[r] & rail_en_i[r] & ~fault_q;
        assign expire[r] = watch && (cnt_q == LAST);

        always_ff @(posedge clk) begin
            if (!rst_n || clr_i || !watch) cnt_q <= '0;
            else if (cnt_q != LAST)        cnt_q <= cnt_q + 1'b1;
        end

        // R11: a switched-off rail keeps its qualification count at zero
        assert_mask_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !rail_en_i[r] |=> (cnt_q == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            fault_q <= 1'b0;
            lin_q   <= 1'b0;
        end else begin
            fault_q <= fault_q | (|expire);
            lin_q   <= ~(fault_q | (|expire));
        end
    end

    assign fault_o = fault_q;
    assign lin_o   = lin_q;

    // R12: latch is sticky while not cleared
    assert_fault_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !clr_i) |=> fault_q);

    // R10: a fault only appears after an undervoltage on an enabled rail
    assert_fault_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_q && !(|(uv_i & rail_en_i))) |=> !fault_q);

    // R7: regulator enable and fault are never both high
    assert_lin_vs_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lin_q && fault_q));

endmodule

// File: rtl/acpi_rail_seq.sv
module acpi_rail_seq
    import rail_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned FAULT_MS    = 50,
    parameter int unsigned TIMEOUT_CYC = (CLK_HZ / 1000) * FAULT_MS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       sby_good_i,
    input  logic       sleep3_n_i,
    input  logic       sleep5_n_i,
    input  logic       main_good_i,
    input  logic       keep_usb_i,
    input  logic       keep_pci_i,
    input  logic [1:0] uv_flag_i,
    output logic       gate_main5_o,
    output logic       gate_main3_o,
    output logic       gate_sby5_o,
    output logic       gate_sby3_o,
    output logic       gate_lin_o
);

    logic                live;
    logic                fault;
    logic                lin;
    logic                main_g, sby5_g, sby3_g;
    logic [RAIL_CNT-1:0] rail_en;
    pwr_state_e          state;

    assign live = enable_i & sby_good_i;

    rs_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .disarm_i    (~live),
        .sleep3_n_i  (sleep3_n_i),
        .sleep5_n_i  (sleep5_n_i),
        .main_good_i (main_good_i),
        .state_o     (state)
    );

    rs_gate_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .live_i     (live),
        .fault_i    (fault),
        .keep_usb_i (keep_usb_i),
        .keep_pci_i (keep_pci_i),
        .main_o     (main_g),
        .sby5_o     (sby5_g),
        .sby3_o     (sby3_g)
    );

    assign rail_en[RAIL_5V] = main_g | sby5_g;
    assign rail_en[RAIL_3V] = main_g | sby3_g;

    rs_fault_guard #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (~live),
        .rail_en_i (rail_en),
        .uv_i      (uv_flag_i),
        .fault_o   (fault),
        .lin_o     (lin)
    );

    assign gate_main5_o = main_g;
    assign gate_main3_o = main_g;
    assign gate_sby5_o  = sby5_g;
    assign gate_sby3_o  = sby3_g;
    assign gate_lin_o   = lin & live;

    // R8: disarmed block drives no gate
    assert_disarm_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> !(gate_main5_o | gate_main3_o | gate_sby5_o | gate_sby3_o | gate_lin_o));

    // R3: the two main gates move together
    assert_main_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_main5_o == gate_main3_o);

endmodule

// File: tb/acpi_rail_seq_test.sv
module acpi_rail_seq_test;

    localparam int T = 16;
    localparam int ST_OFF = 0, ST_S0 = 1, ST_S3 = 2, ST_S5 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0, sby_good_i = 1'b1;
    logic sleep3_n_i = 1'b1, sleep5_n_i = 1'b1, main_good_i = 1'b1;
    logic keep_usb_i = 1'b0, keep_pci_i = 1'b0;
    logic [1:0] uv_flag_i = 2'b00;
    logic gate_main5_o, gate_main3_o, gate_sby5_o, gate_sby3_o, gate_lin_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    acpi_rail_seq #(.TIMEOUT_CYC(T)) uut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .sby_good_i(sby_good_i),
        .sleep3_n_i(sleep3_n_i), .sleep5_n_i(sleep5_n_i), .main_good_i(main_good_i),
        .keep_usb_i(keep_usb_i), .keep_pci_i(keep_pci_i), .uv_flag_i(uv_flag_i),
        .gate_main5_o(gate_main5_o), .gate_main3_o(gate_main3_o),
        .gate_sby5_o(gate_sby5_o), .gate_sby3_o(gate_sby3_o), .gate_lin_o(gate_lin_o)
    );

    function automatic logic [4:0] gates();
        return {gate_main5_o, gate_main3_o, gate_sby5_o, gate_sby3_o, gate_lin_o};
    endfunction

    // {main5, main3, sby5, sby3, lin} for an armed, fault-free block
    function automatic logic [4:0] expect_v(int st, logic usb, logic pci);
        logic m, s5, s3;
        m  = (st == ST_S0);
        s5 = (st == ST_S3) || (st == ST_S5 && usb);
        s3 = (st == ST_S3) || (st == ST_S5 && pci);
        return {m, m, s5, s3, 1'b1};
    endfunction

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gates=%05b expected=%05b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic req(logic s3n, logic s5n, logic pok);
        sleep3_n_i = s3n; sleep5_n_i = s5n; main_good_i = pok;
        step();
    endtask

    task automatic t_reset();
        chk("R8 reset", gates(), 5'b00000);
        rst_n = 1'b1;
        sleep3_n_i = 1'b0; sleep5_n_i = 1'b1;
        step(2);
        chk("R8 enable low", gates(), 5'b00000);
        enable_i = 1'b1;
        step();
        chk("R8 first request S3", gates(), expect_v(ST_S3, 0, 0));
    endtask

    task automatic t_truth_table();
        req(1, 1, 1);
        for (int k = 0; k < 4; k++) begin
            keep_usb_i = k[0]; keep_pci_i = k[1]; step();
            chk("R1 R3 R6 S0 row", gates(), expect_v(ST_S0, k[0], k[1]));
        end
        req(0, 1, 1);
        for (int k = 0; k < 4; k++) begin
            keep_usb_i = k[0]; keep_pci_i = k[1]; step();
            chk("R1 R4 R5 R6 S3 row", gates(), expect_v(ST_S3, k[0], k[1]));
        end
        req(1, 1, 1);
        req(0, 0, 1);
        for (int k = 0; k < 4; k++) begin
            keep_usb_i = k[0]; keep_pci_i = k[1]; step();
            chk("R1 R4 R5 S5 row", gates(), expect_v(ST_S5, k[0], k[1]));
        end
    endtask

    task automatic t_block_s3_s5();
        keep_usb_i = 1'b0; keep_pci_i = 1'b0;
        req(0, 1, 1);
        req(0, 0, 1);
        step(3);
        chk("R2 S3 to S5 refused", gates(), expect_v(ST_S3, 0, 0));
        req(1, 1, 1);
        chk("R2 via S0", gates(), expect_v(ST_S0, 0, 0));
        req(0, 0, 1);
        chk("R2 S0 to S5", gates(), expect_v(ST_S5, 0, 0));
    endtask

    task automatic t_holds();
        req(1, 1, 1);
        req(1, 1, 0);
        step(3);
        chk("R9 supply-good low holds S0", gates(), expect_v(ST_S0, 0, 0));
        req(1, 0, 1);
        step(2);
        chk("R8 invalid pair holds S0", gates(), expect_v(ST_S0, 0, 0));
        req(0, 1, 1);
        req(1, 0, 1);
        chk("R8 invalid pair holds S3", gates(), expect_v(ST_S3, 0, 0));
        req(1, 1, 1);
    endtask

    task automatic t_glitch();
        uv_flag_i = 2'b01;
        step(T - 1);
        uv_flag_i = 2'b00;
        step();
        chk("R10 run of T-1 no fault", gates(), expect_v(ST_S0, 0, 0));
        uv_flag_i = 2'b10; step(T - 1);
        uv_flag_i = 2'b00; step();
        uv_flag_i = 2'b10; step(T - 1);
        chk("R10 counter restarts", gates(), expect_v(ST_S0, 0, 0));
        step();
        chk("R10 latch at T-th edge", gates(), 5'b00000);
        uv_flag_i = 2'b00;
        step(3);
        chk("R12 fault sticky", gates(), 5'b00000);
    endtask

    task automatic t_clear_enable();
        enable_i = 1'b0; step();
        chk("R8 R12 enable low dark", gates(), 5'b00000);
        enable_i = 1'b1; step();
        chk("R12 R7 cleared by enable toggle", gates(), expect_v(ST_S0, 0, 0));
    endtask

    task automatic t_clear_supply();
        uv_flag_i = 2'b01; step(T);
        chk("R10 R12 fault latched", gates(), 5'b00000);
        uv_flag_i = 2'b00;
        sby_good_i = 1'b0; step();
        chk("R8 standby loss dark", gates(), 5'b00000);
        sby_good_i = 1'b1; step();
        chk("R12 R7 cleared by standby loss", gates(), expect_v(ST_S0, 0, 0));
    endtask

    task automatic t_mask();
        keep_usb_i = 1'b0; keep_pci_i = 1'b1;
        req(0, 0, 1);
        uv_flag_i = 2'b01;
        step(T + 5);
        chk("R11 disabled rail masked", gates(), expect_v(ST_S5, 0, 1));
        uv_flag_i = 2'b11;
        step(T - 1);
        chk("R11 enabled rail counting", gates(), expect_v(ST_S5, 0, 1));
        step();
        chk("R10 R11 standby rail fault", gates(), 5'b00000);
        uv_flag_i = 2'b00;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        t_truth_table();
        t_block_s3_s5();
        t_holds();
        t_glitch();
        t_clear_enable();
        t_clear_supply();
        t_mask();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule